// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Interrupts

This block watches the two access ports of a true dual-port RAM and turns the two highest word addresses into doorbells. When one port writes its outgoing mailbox word, an interrupt is raised toward the opposite port. The receiving port acknowledges by reading that same word, and the read drops its interrupt. The mailbox words keep their full data width. They stay ordinary RAM storage held in the array next to this block, so the message content is whatever software puts there.

The left port's incoming mailbox is the address one below the maximum. The right port's incoming mailbox is the maximum address. A static enable turns the function on or off. While it is off, the two top words are plain memory and neither interrupt can be raised. Both interrupt outputs are registered and active low.

Top module: `mailbox_irq`

## Requirements
- R1: During and after synchronous reset, `l_irq_n` and `r_irq_n` are both 1 (deasserted).
- R2: A right-port write (`r_sel`=1, `r_rd_nwr`=0) to address 2^AW-2 while `mbox_en`=1 drives `l_irq_n` to 0 from the clock edge that samples the write onward.
- R3: A left-port read (`l_sel`=1, `l_rd_nwr`=1) of address 2^AW-2 returns `l_irq_n` to 1 on the edge that samples it, unless R6 applies.
- R4: A left-port write to address 2^AW-1 drives `r_irq_n` to 0 on the sampling edge. A right-port read of 2^AW-1 returns it to 1 on the sampling edge, unless R6 applies.
- R5: An interrupt keeps its value when no setting write and no clearing read reach it. This covers a port writing its own incoming mailbox, a port reading the other port's incoming mailbox, and accesses with the port's select at 0.
- R6: If a setting write and a clearing read reach the same interrupt in the same cycle, the interrupt ends up asserted.
- R7: While `mbox_en`=0, both interrupts are deasserted one edge later, and no access raises them.
- R8: Accesses to any address below 2^AW-2 neither set nor clear either interrupt.
- R9: Left and right interrupts are independent. Both can be set in the same cycle, and each clears only through its own port's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mbox_en | input | 1 | Mailbox function enable (static) |
| l_sel | input | 1 | Left port access valid (chip enable, active high) |
| l_rd_nwr | input | 1 | Left port direction: 1 read, 0 write |
| l_addr | input | AW | Left port word address |
| r_sel | input | 1 | Right port access valid (chip enable, active high) |
| r_rd_nwr | input | 1 | Right port direction: 1 read, 0 write |
| r_addr | input | AW | Right port word address |
| l_irq_n | output | 1 | Interrupt to left port, active low |
| r_irq_n | output | 1 | Interrupt to right port, active low |

## Verification
On every cycle, the assertions check the one-edge set and clear behaviour of each interrupt, the set-over-clear priority, hold when neither event is present, and forced deassertion while disabled. The bench's scenarios are what show the decoding corners. These include a port hitting its own mailbox, reads of the wrong mailbox, deselected accesses, and addresses just below the mailboxes. The scenarios also show simultaneous doorbells in both directions, with each one later cleared on its own.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        PORT_L = 1'b0,
        PORT_R = 1'b1
    } port_id_t;

    typedef struct packed {
        logic sel;
        logic rd_nwr;
    } ctl_t;

    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
    } hit_t;

    function automatic logic is_write(input ctl_t c);
        return c.sel && !c.rd_nwr;
    endfunction

    function automatic logic is_read(input ctl_t c);
        return c.sel && c.rd_nwr;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int AW = 18,
    parameter logic [AW-1:0] OUT_ADDR = '1,
    parameter logic [AW-1:0] IN_ADDR  = '1
) (
    input  ctl_t          ctl,
    input  logic [AW-1:0] addr,
    output hit_t          hit
);
    always_comb begin
        hit.wr_hit = is_write(ctl) && (addr == OUT_ADDR);
        hit.rd_hit = is_read(ctl)  && (addr == IN_ADDR);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    assign irq_n = ~pending;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (en && set && clr) |=> !irq_n); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !set && !clr) |=> $stable(irq_n)); // R5
endmodule

// File: rtl/mailbox_irq.sv
module mailbox_irq
    import mbx_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mbox_en,
    input  logic          l_sel,
    input  logic          l_rd_nwr,
    input  logic [AW-1:0] l_addr,
    input  logic          r_sel,
    input  logic          r_rd_nwr,
    input  logic [AW-1:0] r_addr,
    output logic          l_irq_n,
    output logic          r_irq_n
);
    localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
    localparam int NPORT = 2;

    ctl_t          ctl_a  [NPORT];
    logic [AW-1:0] addr_a [NPORT];
    hit_t          hit_a  [NPORT];
    logic          irqn_a [NPORT];

    always_comb begin
        ctl_a[PORT_L]  = '{sel: l_sel, rd_nwr: l_rd_nwr};
        ctl_a[PORT_R]  = '{sel: r_sel, rd_nwr: r_rd_nwr};
        addr_a[PORT_L] = l_addr;
        addr_a[PORT_R] = r_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // left sends to TOP, receives at NEXT; right the opposite
        localparam logic [AW-1:0] OUT_A = (p == 0) ? TOP_ADDR : NEXT_ADDR;
        localparam logic [AW-1:0] IN_A  = (p == 0) ? NEXT_ADDR : TOP_ADDR;

        mbx_decode #(
            .AW(AW), .OUT_ADDR(OUT_A), .IN_ADDR(IN_A)
        ) i_dec (
            .ctl  (ctl_a[p]),
            .addr (addr_a[p]),
            .hit  (hit_a[p])
        );

        mbx_flag i_flag (
            .clk   (clk),
            .rst   (rst),
            .en    (mbox_en),
            .set   (hit_a[NPORT-1-p].wr_hit),
            .clr   (hit_a[p].rd_hit),
            .irq_n (irqn_a[p])
        );
    end

    assign l_irq_n = irqn_a[PORT_L];
    assign r_irq_n = irqn_a[PORT_R];

    AST_L_SET: assert property (@(posedge clk) disable iff (rst)
        (mbox_en && r_sel && !r_rd_nwr && r_addr == NEXT_ADDR) |=> !l_irq_n); // R2
    AST_L_CLR: assert property (@(posedge clk) disable iff (rst)
        (mbox_en && l_sel && l_rd_nwr && l_addr == NEXT_ADDR
         && !(r_sel && !r_rd_nwr && r_addr == NEXT_ADDR)) |=> l_irq_n); // R3
    AST_R_SET: assert property (@(posedge clk) disable iff (rst)
        (mbox_en && l_sel && !l_rd_nwr && l_addr == TOP_ADDR) |=> !r_irq_n); // R4
    AST_R_CLR: assert property (@(posedge clk) disable iff (rst)
        (mbox_en && r_sel && r_rd_nwr && r_addr == TOP_ADDR
         && !(l_sel && !l_rd_nwr && l_addr == TOP_ADDR)) |=> r_irq_n); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mbox_en |=> (l_irq_n && r_irq_n)); // R7
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (l_irq_n && r_irq_n)); // R1
endmodule

// File: tb/test_mailbox_irq.sv
module test_mailbox_irq;
    localparam int  AW      = 18;
    localparam time CLK_PER = 10;
    localparam int  TOPA    = (1 << AW) - 1;
    localparam int  NEXTA   = (1 << AW) - 2;

    logic clk = 1'b0;
    logic rst, mbox_en;
    logic l_sel, l_rd_nwr, r_sel, r_rd_nwr;
    logic [AW-1:0] l_addr, r_addr;
    logic l_irq_n, r_irq_n;

    int total = 0;
    int bad   = 0;
    string tag = "R1";
    bit exp_l = 1'b0; // 1 = interrupt pending
    bit exp_r = 1'b0;
    bit done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    mailbox_irq #(.AW(AW)) i_mailbox_irq (
        .clk(clk), .rst(rst), .mbox_en(mbox_en),
        .l_sel(l_sel), .l_rd_nwr(l_rd_nwr), .l_addr(l_addr),
        .r_sel(r_sel), .r_rd_nwr(r_rd_nwr), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst || !mbox_en) begin
            exp_l <= 1'b0;
            exp_r <= 1'b0;
        end else begin
            if (r_sel && !r_rd_nwr && int'(r_addr) == NEXTA) exp_l <= 1'b1;
            else if (l_sel && l_rd_nwr && int'(l_addr) == NEXTA) exp_l <= 1'b0;
            if (l_sel && !l_rd_nwr && int'(l_addr) == TOPA) exp_r <= 1'b1;
            else if (r_sel && r_rd_nwr && int'(r_addr) == TOPA) exp_r <= 1'b0;
        end
    end

    // compare on every falling edge, once the registered outputs have settled
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (l_irq_n !== !exp_l || r_irq_n !== !exp_r) begin
                bad++;
                $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                         tag, l_irq_n, r_irq_n, !exp_l, !exp_r);
            end
        end
    end

    task automatic step(input string t, input bit ls, input bit lr, input int la,
                        input bit rs, input bit rr, input int ra);
        @(negedge clk);
        #1;
        tag = t;
        l_sel = ls; l_rd_nwr = lr; l_addr = la[AW-1:0];
        r_sel = rs; r_rd_nwr = rr; r_addr = ra[AW-1:0];
    endtask

    task automatic idle(input string t, input int n);
        for (int i = 0; i < n; i++) step(t, 0, 1, 0, 0, 1, 0);
    endtask

    task automatic expect_now(input string t, input bit l, input bit r);
        @(negedge clk);
        total++;
        if (l_irq_n !== !l || r_irq_n !== !r) begin
            bad++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                     t, l_irq_n, r_irq_n, !l, !r);
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        bad++;
        $display("FAIL watchdog: run did not end");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mbox_en = 1'b1;
        l_sel = 0; l_rd_nwr = 1; l_addr = '0;
        r_sel = 0; r_rd_nwr = 1; r_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle("R1", 2);
        expect_now("R1", 0, 0);
        // R2: right writes left's mailbox
        step("R2", 0, 1, 0, 1, 0, NEXTA);
        idle("R2", 2);
        expect_now("R2", 1, 0);
        // R5: left reading top (right's box) does not clear left
        step("R5", 1, 1, TOPA, 0, 1, 0);
        // R5: deselected read of the left box does not clear
        step("R5", 0, 1, NEXTA, 0, 1, 0);
        // R8: address below mailboxes
        step("R8", 1, 1, NEXTA - 1, 1, 0, NEXTA - 1);
        idle("R8", 1);
        expect_now("R8", 1, 0);
        // R3: left reads its mailbox
        step("R3", 1, 1, NEXTA, 0, 1, 0);
        idle("R3", 1);
        expect_now("R3", 0, 0);
        // R5: left writing its own incoming box does not raise it
        step("R5", 1, 0, NEXTA, 1, 0, TOPA);
        idle("R5", 1);
        expect_now("R5", 0, 0);
        // R4: left writes right's mailbox, right reads to clear
        step("R4", 1, 0, TOPA, 0, 1, 0);
        idle("R4", 1);
        expect_now("R4", 0, 1);
        step("R4", 0, 1, 0, 1, 1, TOPA);
        idle("R4", 1);
        expect_now("R4", 0, 0);
        // R9: both doorbells at once, cleared separately
        step("R9", 1, 0, TOPA, 1, 0, NEXTA);
        idle("R9", 1);
        expect_now("R9", 1, 1);
        step("R9", 1, 1, NEXTA, 0, 1, 0);
        idle("R9", 1);
        expect_now("R9", 0, 1);
        step("R9", 0, 1, 0, 1, 1, TOPA);
        idle("R9", 1);
        expect_now("R9", 0, 0);
        // R6: set and clear collide on each flag
        step("R6", 1, 1, NEXTA, 1, 0, NEXTA);
        idle("R6", 1);
        expect_now("R6", 1, 0);
        step("R6", 1, 0, TOPA, 1, 1, TOPA);
        idle("R6", 1);
        expect_now("R6", 1, 1);
        // R7: disabling clears and blocks setting
        mbox_en = 1'b0;
        idle("R7", 2);
        expect_now("R7", 0, 0);
        step("R7", 1, 0, TOPA, 1, 0, NEXTA);
        idle("R7", 2);
        expect_now("R7", 0, 0);
        mbox_en = 1'b1;
        idle("R7", 2);
        expect_now("R7", 0, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule